// File: doc/BRIEF.md
# Claim/Complete Interrupt Hub

This block gathers level interrupt lines from a set of numbered sources and presents them to several target contexts. Each context sits on one hart and runs in either machine or supervisor mode. It drives the request line that matches that mode on its hart. Software reaches the block over a plain 32-bit read/write bus. Through that bus it sets a priority for each source, reads which sources are pending, chooses per context which sources may interrupt it, and sets a per-context threshold. It then takes and returns interrupts through a per-context claim/complete word.

A context asks for service while some source is pending, enabled for it, not yet claimed, and above its threshold. Reading the context's claim word returns the best such source. In the same clock edge that source leaves the pending set and joins the claimed set, so every context stops seeing it. Writing the source number back to the same word releases the claim. Source number 0 means "nothing" and is never pending.

Top module: `irq_hub`

## Requirements
- R1: After reset every priority, threshold, enable bit, pending bit and claimed bit is zero. The error flag is low, every request line is low, and a claim read returns 0.
- R2: The 32-bit word at PRIO_BASE + 4*(k-1) holds the priority of source k, for k = 1 to N_SRC-1. A write keeps only the low PRIO_W (3) bits, and a read returns those bits zero-extended.
- R3: When a source input changes level, its pending bit takes the new level on that clock edge. Source 0 never becomes pending. Bit i of the word at PEND_BASE + 4*(i/32), position i%32, reads pending bit i. A write there changes nothing and sets the error flag.
- R4: The enable bits of context c sit at EN_BASE + c*EN_STRIDE + 4*w, with bit b%32 of word w = b/32 enabling source b. Bits and words at or beyond N_SRC read as zero, and writes to them have no effect.
- R5: In the window at CTX_BASE + c*CTX_STRIDE, offset 0 is the threshold. A threshold write is taken only when the value is at most N_LEVELS, and a larger value is dropped. Every offset other than 0 and 4 reads as zero, ignores writes and does not set the error flag.
- R6: The winner of a context is chosen among sources that are pending, unclaimed and enabled for it, and whose priority is strictly above its threshold. The winner is the source with the highest priority; on a tie the lowest source number wins. When no source qualifies, the winner is 0.
- R7: A read of offset 4 of a context window returns that context's winner. If the winner is nonzero, the same clock edge clears its pending bit and sets its claimed bit, so two claim reads on consecutive cycles never return the same source.
- R8: A write to offset 4 whose value is below N_SRC clears the claimed bit of that source. Any other value is ignored. Completing a source does not make it pending again; only a later change of its input does.
- R9: Each context drives m_irq (machine mode) or s_irq (supervisor mode) of its hart, as set by CTX_SUPV and CTX_HART. The line is high one clock after the context's winner becomes nonzero and low one clock after it becomes zero.
- R10: An access to an address outside every window returns zero on a read, changes no state, and sets bus_err. bus_err stays high until reset.
- R11: bus_rvalid is high exactly in the cycle after a read request, and bus_rdata carries the read data in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_in | input | N_SRC | Level interrupt inputs, bit i is source i (bit 0 unused) |
| bus_req | input | 1 | Access request, one access per cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address of a 32-bit word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read request |
| bus_err | output | 1 | Sticky flag for unmapped accesses and pending-bitmap writes |
| m_irq | output | N_HART | Machine-mode request line per hart |
| s_irq | output | N_HART | Supervisor-mode request line per hart |

## Verification
The bench goes after the places where the arbitration can go quietly wrong. Two sources of equal priority must resolve to the lower number, and a design that kept the later one would claim source 2 before source 1. A priority equal to the threshold must not win, and an off-by-one compare would raise a line that should stay low. Two claim reads on consecutive cycles must return different sources, which a design that delayed the claimed-bit update by a cycle would fail by returning the same source twice. Completions with an out-of-range number, writes to the pending words, enable words beyond the source count and unmapped holes between windows must all leave state untouched. A design that decoded loosely would corrupt priorities, enables or claim state, and a sweep of mixed priority, enable, threshold and input patterns compares every claim against an arithmetic model.

// File: rtl/irq_hub_pkg.sv
`timescale 1ns/1ps
package irq_hub_pkg;

  typedef enum logic [2:0] {
    RG_NONE,
    RG_PRIO,
    RG_PEND,
    RG_EN,
    RG_CTX
  } region_e;

  // true when a lies in [base, base + size)
  function automatic logic in_window(input logic [31:0] a,
                                     input logic [31:0] base,
                                     input logic [31:0] size);
    return (a >= base) && ((a - base) < size);
  endfunction

endpackage

// File: rtl/irq_hub_arb.sv
`timescale 1ns/1ps
module irq_hub_arb #(
  parameter int unsigned N_SRC  = 8,
  parameter int unsigned PRIO_W = 3,
  parameter int unsigned ID_W   = 3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [N_SRC-1:0]        cand,
  input  logic [N_SRC*PRIO_W-1:0] prio_flat,
  input  logic [PRIO_W-1:0]       thresh,
  output logic [ID_W-1:0]         win_id
);

  logic [PRIO_W-1:0] best;

  // ascending scan with strict compare: ties keep the lower id
  always_comb begin
    best   = thresh;
    win_id = '0;
    for (int unsigned i = 1; i < N_SRC; i++) begin
      if (cand[i] && (prio_flat[i*PRIO_W +: PRIO_W] > best)) begin
        best   = prio_flat[i*PRIO_W +: PRIO_W];
        win_id = ID_W'(i);
      end
    end
  end

  // R6
  win_qualifies_chk: assert property (@(posedge clk) disable iff (rst)
    (win_id != '0) |-> (cand[win_id] &&
      (prio_flat[32'(win_id)*PRIO_W +: PRIO_W] > thresh)));

endmodule

// File: rtl/irq_hub_src.sv
`timescale 1ns/1ps
module irq_hub_src #(
  parameter int unsigned N_SRC = 8,
  parameter int unsigned ID_W  = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] src_in,
  input  logic             take_en,
  input  logic [ID_W-1:0]  take_id,
  input  logic             done_en,
  input  logic [ID_W-1:0]  done_id,
  output logic [N_SRC-1:0] pend_o,
  output logic [N_SRC-1:0] clmd_o
);

  logic [N_SRC-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= '0;
      pend_o <= '0;
      clmd_o <= '0;
    end else begin
      prev_q <= src_in;
      for (int unsigned i = 1; i < N_SRC; i++) begin
        if (src_in[i] != prev_q[i]) begin
          pend_o[i] <= src_in[i];
        end else if (take_en && (take_id == ID_W'(i))) begin
          pend_o[i] <= 1'b0;
        end
        if (take_en && (take_id == ID_W'(i))) begin
          clmd_o[i] <= 1'b1;
        end else if (done_en && (done_id == ID_W'(i))) begin
          clmd_o[i] <= 1'b0;
        end
      end
    end
  end

  // R7
  take_sets_chk: assert property (@(posedge clk) disable iff (rst)
    (take_en && (take_id != '0)) |=> clmd_o[$past(take_id)]);

  // R8
  done_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (done_en && (done_id != '0)) |=> !clmd_o[$past(done_id)]);

endmodule

// File: rtl/irq_hub.sv
`timescale 1ns/1ps
module irq_hub
  import irq_hub_pkg::*;
#(
  parameter int unsigned N_SRC      = 8,
  parameter int unsigned N_CTX      = 3,
  parameter int unsigned N_HART     = 2,
  parameter int unsigned PRIO_W     = 3,
  parameter int unsigned N_LEVELS   = 7,
  parameter int unsigned ADDR_W     = 16,
  parameter int unsigned PRIO_BASE  = 32'h0000,
  parameter int unsigned PEND_BASE  = 32'h0400,
  parameter int unsigned EN_BASE    = 32'h0800,
  parameter int unsigned EN_STRIDE  = 32'h0040,
  parameter int unsigned CTX_BASE   = 32'h1000,
  parameter int unsigned CTX_STRIDE = 32'h0100,
  parameter logic [N_CTX-1:0]   CTX_SUPV = 3'b010,
  parameter logic [4*N_CTX-1:0] CTX_HART = 12'h100
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_SRC-1:0]  src_in,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              bus_rvalid,
  output logic              bus_err,
  output logic [N_HART-1:0] m_irq,
  output logic [N_HART-1:0] s_irq
);

  localparam int unsigned ID_W    = $clog2(N_SRC);
  localparam int unsigned CI_W    = (N_CTX > 1) ? $clog2(N_CTX) : 1;
  localparam int unsigned N_WORDS = (N_SRC + 31) / 32;
  localparam int unsigned EN_SH   = $clog2(EN_STRIDE);
  localparam int unsigned CTX_SH  = $clog2(CTX_STRIDE);

  logic [PRIO_W-1:0]       prio_q [N_SRC];
  logic [N_SRC-1:0]        en_q   [N_CTX];
  logic [PRIO_W-1:0]       thr_q  [N_CTX];
  logic [ID_W-1:0]         win    [N_CTX];
  logic [N_SRC*PRIO_W-1:0] prio_flat;
  logic [N_SRC-1:0]        pend, clmd;

  // ---------------- address decode ----------------
  logic [31:0]  a32;
  region_e      rgn;
  int unsigned  idx, sub;
  logic [CI_W-1:0] ctx_sel;
  logic [ID_W-1:0] src_sel;
  logic rd_op, wr_op;

  assign a32   = 32'(bus_addr);
  assign rd_op = bus_req && !bus_we;
  assign wr_op = bus_req && bus_we;

  always_comb begin
    rgn = RG_NONE;
    idx = 0;
    sub = 0;
    if (in_window(a32, PRIO_BASE, (N_SRC - 1) * 4)) begin
      rgn = RG_PRIO;
      idx = ((a32 - PRIO_BASE) >> 2) + 1;
    end else if (in_window(a32, PEND_BASE, N_WORDS * 4)) begin
      rgn = RG_PEND;
      idx = (a32 - PEND_BASE) >> 2;
    end else if (in_window(a32, EN_BASE, N_CTX * EN_STRIDE)) begin
      rgn = RG_EN;
      idx = (a32 - EN_BASE) >> EN_SH;
      sub = ((a32 - EN_BASE) & (EN_STRIDE - 1)) >> 2;
    end else if (in_window(a32, CTX_BASE, N_CTX * CTX_STRIDE)) begin
      rgn = RG_CTX;
      idx = (a32 - CTX_BASE) >> CTX_SH;
      sub = (a32 - CTX_BASE) & (CTX_STRIDE - 1);
    end
  end

  assign ctx_sel = CI_W'(idx);
  assign src_sel = ID_W'(idx);

  // ---------------- claim / complete ----------------
  logic            take_en, done_en;
  logic [ID_W-1:0] take_id, done_id;

  assign take_id = win[ctx_sel];
  assign take_en = rd_op && (rgn == RG_CTX) && (sub == 4) && (take_id != '0);
  assign done_id = ID_W'(bus_wdata);
  assign done_en = wr_op && (rgn == RG_CTX) && (sub == 4) && (bus_wdata < N_SRC);

  irq_hub_src #(.N_SRC(N_SRC), .ID_W(ID_W)) u_src (
    .clk     (clk),
    .rst     (rst),
    .src_in  (src_in),
    .take_en (take_en),
    .take_id (take_id),
    .done_en (done_en),
    .done_id (done_id),
    .pend_o  (pend),
    .clmd_o  (clmd)
  );

  // ---------------- per-context arbitration ----------------
  for (genvar s = 0; s < N_SRC; s++) begin : g_flat
    assign prio_flat[s*PRIO_W +: PRIO_W] = prio_q[s];
  end

  for (genvar c = 0; c < N_CTX; c++) begin : g_ctx
    localparam int unsigned HC = int'(CTX_HART[4*c +: 4]);

    irq_hub_arb #(.N_SRC(N_SRC), .PRIO_W(PRIO_W), .ID_W(ID_W)) u_arb (
      .clk       (clk),
      .rst       (rst),
      .cand      (pend & ~clmd & en_q[c]),
      .prio_flat (prio_flat),
      .thresh    (thr_q[c]),
      .win_id    (win[c])
    );

    // R5
    thr_bound_chk: assert property (@(posedge clk) disable iff (rst)
      32'(thr_q[c]) <= N_LEVELS);

    if (CTX_SUPV[c]) begin : g_s
      // R9
      s_line_chk: assert property (@(posedge clk) disable iff (rst)
        (win[c] != '0) |=> s_irq[HC]);
    end else begin : g_m
      // R9
      m_line_chk: assert property (@(posedge clk) disable iff (rst)
        (win[c] != '0) |=> m_irq[HC]);
    end
  end

  // ---------------- read mux ----------------
  logic [31:0] rd_next;

  always_comb begin
    rd_next = '0;
    unique case (rgn)
      RG_PRIO: rd_next = 32'(prio_q[src_sel]);
      RG_PEND: begin
        for (int unsigned b = 0; b < N_SRC; b++)
          if (b / 32 == idx) rd_next[b % 32] = pend[b];
      end
      RG_EN: begin
        for (int unsigned b = 0; b < N_SRC; b++)
          if (b / 32 == sub) rd_next[b % 32] = en_q[ctx_sel][b];
      end
      RG_CTX: begin
        if (sub == 0)      rd_next = 32'(thr_q[ctx_sel]);
        else if (sub == 4) rd_next = 32'(take_id);
      end
      default: rd_next = '0;
    endcase
  end

  // ---------------- register state ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int unsigned s = 0; s < N_SRC; s++) prio_q[s] <= '0;
      for (int unsigned c = 0; c < N_CTX; c++) begin
        en_q[c]  <= '0;
        thr_q[c] <= '0;
      end
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
      bus_err    <= 1'b0;
    end else begin
      bus_rvalid <= rd_op;
      if (rd_op) bus_rdata <= rd_next;
      if (bus_req && ((rgn == RG_NONE) || ((rgn == RG_PEND) && bus_we)))
        bus_err <= 1'b1;
      if (wr_op) begin
        unique case (rgn)
          RG_PRIO: prio_q[src_sel] <= bus_wdata[PRIO_W-1:0];
          RG_EN: begin
            for (int unsigned b = 0; b < N_SRC; b++)
              if (b / 32 == sub) en_q[ctx_sel][b] <= bus_wdata[b % 32];
          end
          RG_CTX: begin
            if ((sub == 0) && (bus_wdata <= N_LEVELS))
              thr_q[ctx_sel] <= PRIO_W'(bus_wdata);
          end
          default: ;
        endcase
      end
    end
  end

  // ---------------- request lines ----------------
  logic [N_HART-1:0] m_nx, s_nx;

  always_comb begin
    m_nx = '0;
    s_nx = '0;
    for (int unsigned c = 0; c < N_CTX; c++) begin
      for (int unsigned h = 0; h < N_HART; h++) begin
        if ((CTX_HART[4*c +: 4] == 4'(h)) && (win[c] != '0)) begin
          if (CTX_SUPV[c]) s_nx[h] = 1'b1;
          else             m_nx[h] = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      m_irq <= '0;
      s_irq <= '0;
    end else begin
      m_irq <= m_nx;
      s_irq <= s_nx;
    end
  end

  // R10
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    bus_err |=> bus_err);

  // R11
  rvalid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    rd_op |=> bus_rvalid);

  // R11
  rvalid_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_op |=> !bus_rvalid);

endmodule

// File: tb/irq_hub_tb.sv
`timescale 1ns/1ps
module irq_hub_tb_top;

  localparam int unsigned NS = 8;
  localparam int unsigned NC = 3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  src_in = '0;
  logic        bus_req = 1'b0;
  logic        bus_we = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid, bus_err;
  logic [1:0]  m_irq, s_irq;

  always #2.5 clk = ~clk;

  irq_hub dut_i (
    .clk(clk), .rst(rst), .src_in(src_in),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .bus_err(bus_err), .m_irq(m_irq), .s_irq(s_irq)
  );

  int n_chk = 0;
  int n_fail = 0;

  // model state
  int       m_prio [NS];
  logic [7:0] m_en [NC];
  int       m_thr  [NC];
  logic [7:0] m_pend, m_clm;

  function automatic int a_prio(int s);       return 4 * (s - 1); endfunction
  function automatic int a_en(int c, int w);  return 'h800 + c * 'h40 + 4 * w; endfunction
  function automatic int a_thr(int c);        return 'h1000 + c * 'h100; endfunction
  function automatic int a_clm(int c);        return 'h1000 + c * 'h100 + 4; endfunction
  localparam int A_PEND = 'h400;

  function automatic int mwin(int c);
    int best = m_thr[c];
    int w = 0;
    for (int s = 1; s < NS; s++)
      if (m_pend[s] && !m_clm[s] && m_en[c][s] && m_prio[s] > best) begin
        best = m_prio[s];
        w = s;
      end
    return w;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input int ad, input logic [31:0] d);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b1; bus_addr = 16'(ad); bus_wdata = d;
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input int ad, output logic [31:0] d);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b0; bus_addr = 16'(ad);
    @(negedge clk);
    bus_req = 1'b0;
    d = bus_rdata;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; src_in = '0; bus_req = 1'b0; bus_we = 1'b0;
    wait_n(2);
    rst = 1'b0;
    for (int s = 0; s < NS; s++) m_prio[s] = 0;
    for (int c = 0; c < NC; c++) begin m_en[c] = '0; m_thr[c] = 0; end
    m_pend = '0; m_clm = '0;
  endtask

  task automatic set_src(input logic [7:0] v);
    @(negedge clk);
    for (int s = 1; s < NS; s++) if (v[s] != src_in[s]) m_pend[s] = v[s];
    src_in = v;
    wait_n(3);
  endtask

  task automatic chk_lines(input string tag);
    chk({tag, " R9 m0"}, 32'(m_irq[0]), 32'(mwin(0) != 0));
    chk({tag, " R9 s0"}, 32'(s_irq[0]), 32'(mwin(1) != 0));
    chk({tag, " R9 m1"}, 32'(m_irq[1]), 32'(mwin(2) != 0));
    chk({tag, " R9 s1"}, 32'(s_irq[1]), 32'd0);
  endtask

  task automatic claim_chk(input int c, input string tag);
    logic [31:0] d;
    int w = mwin(c);
    rd(a_clm(c), d);
    chk({tag, " R7 claim"}, d, 32'(w));
    if (w != 0) begin m_pend[w] = 1'b0; m_clm[w] = 1'b1; end
  endtask

  initial begin : watchdog
    #1ms;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : main
    logic [31:0] d, d2;
    do_reset();

    // R1 reset state
    chk("R1 m_irq", 32'(m_irq), 0);
    chk("R1 s_irq", 32'(s_irq), 0);
    chk("R1 err", 32'(bus_err), 0);
    rd(a_prio(3), d);   chk("R1 prio", d, 0);
    rd(a_thr(1), d);    chk("R1 thr", d, 0);
    rd(a_en(2, 0), d);  chk("R1 en", d, 0);
    rd(A_PEND, d);      chk("R1 pend", d, 0);
    rd(a_clm(0), d);    chk("R1 claim", d, 0);

    // R11 read valid timing
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b0; bus_addr = 16'(a_thr(0));
    @(negedge clk);
    bus_req = 1'b0;
    chk("R11 rvalid high", 32'(bus_rvalid), 1);
    @(negedge clk);
    chk("R11 rvalid low", 32'(bus_rvalid), 0);

    // R2 priority sweep
    for (int s = 1; s < NS; s++)
      for (int v = 0; v < 16; v++) begin
        wr(a_prio(s), 32'(v) | 32'hFFFF_FF00);
        rd(a_prio(s), d);
        chk($sformatf("R2 prio s%0d v%0d", s, v), d, 32'(v & 7));
      end

    // R4 enable layout
    wr(a_en(1, 0), 32'hFFFF_FF5A);
    rd(a_en(1, 0), d);  chk("R4 en word0", d, 32'h5A);
    wr(a_en(1, 1), 32'hFFFF_FFFF);
    rd(a_en(1, 1), d);  chk("R4 en beyond", d, 0);
    rd(a_en(1, 0), d);  chk("R4 en kept", d, 32'h5A);
    rd(a_en(0, 0), d);  chk("R4 en other ctx", d, 0);

    // R5 threshold acceptance and other offsets
    wr(a_thr(2), 32'd3);  rd(a_thr(2), d); chk("R5 thr 3", d, 3);
    wr(a_thr(2), 32'd8);  rd(a_thr(2), d); chk("R5 thr 8 dropped", d, 3);
    wr(a_thr(2), 32'd7);  rd(a_thr(2), d); chk("R5 thr 7", d, 7);
    wr(a_thr(2) + 8, 32'd1); rd(a_thr(2) + 8, d); chk("R5 off8 read", d, 0);
    rd(a_thr(2), d); chk("R5 off8 no effect", d, 7);
    chk("R5 no err", 32'(bus_err), 0);

    // R10 unmapped accesses
    do_reset();
    wr(a_prio(1), 32'd5);
    rd('h1C, d);        chk("R10 hole read", d, 0);
    chk("R10 err set", 32'(bus_err), 1);
    wr('h3000, 32'd7);
    wr('h1C, 32'd7);
    rd(a_prio(1), d);   chk("R10 no state change", d, 5);
    rd(a_prio(7), d);   chk("R10 prio7", d, 0);
    chk("R10 err sticky", 32'(bus_err), 1);
    do_reset();
    chk("R1 err cleared", 32'(bus_err), 0);

    // R3 pending follows input level
    set_src(8'h0F);
    rd(A_PEND, d);  chk("R3 pend rise", d, 32'h0E);
    set_src(8'h04);
    rd(A_PEND, d);  chk("R3 pend fall", d, 32'h04);
    wr(A_PEND, 32'hFF);
    rd(A_PEND, d);  chk("R3 pend write ignored", d, 32'h04);
    chk("R3 pend write err", 32'(bus_err), 1);

    // R6/R7 tie order and back-to-back claims
    do_reset();
    wr(a_prio(1), 3); wr(a_prio(2), 3); wr(a_prio(3), 5);
    wr(a_en(0, 0), 32'h0E);
    set_src(8'h0E);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b0; bus_addr = 16'(a_clm(0));
    @(negedge clk);
    d = bus_rdata;
    @(negedge clk);
    bus_req = 1'b0;
    d2 = bus_rdata;
    chk("R7 b2b first", d, 3);
    chk("R6 R7 b2b tie low id", d2, 1);
    rd(a_clm(0), d); chk("R7 third", d, 2);
    rd(a_clm(0), d); chk("R7 empty", d, 0);
    wait_n(2);
    chk("R9 all claimed low", 32'(m_irq), 0);

    // R6 threshold equal does not win
    do_reset();
    wr(a_prio(4), 2); wr(a_en(0, 0), 32'h10); wr(a_thr(0), 2);
    set_src(8'h10);
    chk("R6 equal thr line", 32'(m_irq[0]), 0);
    rd(a_clm(0), d); chk("R6 equal thr claim", d, 0);
    wr(a_thr(0), 1); wait_n(2);
    chk("R9 line after thr drop", 32'(m_irq[0]), 1);

    // R8 complete handling
    do_reset();
    wr(a_prio(2), 4); wr(a_en(0, 0), 32'h04);
    set_src(8'h04);
    rd(a_clm(0), d); chk("R8 claim 2", d, 2);
    wr(a_clm(0), 32'd10);
    set_src(8'h00); set_src(8'h04);
    rd(a_clm(0), d); chk("R8 bad complete ignored", d, 0);
    chk("R8 line still low", 32'(m_irq[0]), 0);
    wr(a_clm(0), 32'd2); wait_n(2);
    chk("R8 line after complete", 32'(m_irq[0]), 1);
    rd(a_clm(0), d); chk("R8 reclaim", d, 2);
    wr(a_clm(0), 32'd2);
    rd(a_clm(0), d); chk("R8 no re-pend", d, 0);

    // model sweep over mixed patterns: R6 R7 R8 R9
    for (int p = 0; p < 48; p++) begin
      string tg;
      tg = $sformatf("sweep p%0d", p);
      do_reset();
      for (int s = 1; s < NS; s++) begin
        m_prio[s] = (p * 5 + s * 3) & 7;
        wr(a_prio(s), 32'(m_prio[s]));
      end
      for (int c = 0; c < NC; c++) begin
        m_en[c] = 8'(((p * 37 + c * 91) ^ 'h5B) & 'hFE);
        wr(a_en(c, 0), 32'(m_en[c]));
        m_thr[c] = (p + c) % 4;
        wr(a_thr(c), 32'(m_thr[c]));
      end
      set_src(8'(((p * 29) + 13) | 1));
      chk_lines(tg);
      for (int c = 0; c < NC; c++) claim_chk(c, tg);
      claim_chk(p % NC, tg);
      wait_n(2);
      chk_lines({tg, " post"});
      for (int s = 1; s < NS; s++)
        if (m_clm[s]) begin
          wr(a_clm(0), 32'(s));
          m_clm[s] = 1'b0;
        end
      rd(A_PEND, d);
      chk({tg, " R3 pend"}, d, 32'(m_pend));
      claim_chk(0, {tg, " R8"});
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule